// File: doc/BRIEF.md
# Interrupt Vector Aggregation Controller

This block collects vector interrupt events and turns them into a small set of level interrupt lines. Each event arrives as a one-cycle strobe that carries an 8-bit vector number. The vector number selects one of up to eight banks of 32 vectors each. Every event sets a sticky cause bit, whether or not that vector is enabled. Each bank drives its own interrupt output. The output is high while at least one bit in the bank is both pending and enabled.

Software uses a 32-bit register port with a byte address. Each bank has a cause word and an enable word. Software reads a cause word to find the vectors that have fired. It writes ones to the cause word to acknowledge them, and bits written with zero stay as they are. Software writes the enable word as a whole word to unmask or mask individual vectors. The `NUM_BANKS` parameter sets how many banks are built. Events and register accesses that point at a bank outside that count have no effect.

Top module: `vecagg_ctrl`

## Requirements
- R1: After reset, all cause bits and all enable bits are 0, every bit of `irq_out` is 0 and `reg_rdata` is 0.
- R2: An event with vector number n, where bank n/32 is below `NUM_BANKS`, sets bit n%32 of the cause word of bank n/32. That cause word is read at byte address 4*(n/32).
- R3: A cause bit stays set until it is cleared. A write to a cause word clears every bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged.
- R4: If an event sets a cause bit in the same cycle that a write clears it, the bit ends up set. Other bits cleared by the same write are still cleared.
- R5: A cause bit latches even when the matching enable bit is 0.
- R6: The enable word of bank i is at byte address 0x20 + 4*i. A write replaces the whole word, where 1 unmasks a vector and 0 masks it, and a read returns the last value written.
- R7: `irq_out[i]` is 1 exactly when the cause word and the enable word of bank i have a set bit in common. It follows any change of either word in the same cycle that the word changes.
- R8: An event whose bank index (vector number bits 7:5) is at or above `NUM_BANKS` changes no state and raises no output.
- R9: An address is unmapped if it is not a multiple of 4, if it is 0x40 or above, or if it names a bank at or above `NUM_BANKS`. A read of an unmapped address returns 0, and a write to one changes nothing.
- R10: A read request is taken at a clock edge. `reg_rdata` then holds the value the addressed word had before that edge, and it keeps that value until the next read.
- R11: Banks are independent. An event or a write aimed at one bank leaves the cause and enable words of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vec_stb | input | 1 | Vector event strobe, one cycle per event |
| vec_num | input | 8 | Vector number carried with the strobe |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq_out | output | NUM_BANKS | One level interrupt per bank |

## Verification
The bench uses single events in the first and last banks it builds, including the highest bit of a word. This shows whether the bank index and the bit position are split correctly from the vector number. Events are tried with the vector both masked and unmasked, which separates the cause latch from the interrupt gating. Cause writes carry ones and zeros in the same word, and one cycle carries an event and a clear of the same bit together, which shows what wins. Events above the built bank count, reads and writes at misaligned, out-of-range and unbuilt-bank addresses, and a read that coincides with an event check the drop rules and the timing of the registered read data.

// File: rtl/vecagg_pkg.sv
package vecagg_pkg;

    localparam int WORD_W         = 32;
    localparam int VEC_W          = 8;
    localparam int ADDR_W         = 8;
    localparam int BIT_IDX_W      = $clog2(WORD_W);
    localparam int BANK_IDX_W     = VEC_W - BIT_IDX_W;
    localparam int MAX_BANKS      = 1 << BANK_IDX_W;
    localparam int BYTES_PER_WORD = WORD_W / 8;
    localparam int SLOT_LSB       = $clog2(BYTES_PER_WORD);
    localparam int REGION_BIT     = SLOT_LSB + BANK_IDX_W;

    typedef logic [WORD_W-1:0]     word_t;
    typedef logic [ADDR_W-1:0]     addr_t;
    typedef logic [VEC_W-1:0]      vec_t;
    typedef logic [BANK_IDX_W-1:0] bank_idx_t;
    typedef logic [BIT_IDX_W-1:0]  bit_idx_t;

    typedef enum logic [1:0] {
        REG_NONE   = 2'd0,
        REG_CAUSE  = 2'd1,
        REG_ENABLE = 2'd2
    } reg_kind_e;

    typedef struct packed {
        logic  valid;
        logic  write;
        addr_t addr;
        word_t wdata;
    } reg_req_t;

    typedef struct packed {
        reg_kind_e kind;
        bank_idx_t bank;
    } reg_sel_t;

    typedef struct packed {
        logic      valid;
        bank_idx_t bank;
        bit_idx_t  bit_pos;
    } vec_evt_t;

    // Map a byte address onto a register kind and a bank index.
    function automatic reg_sel_t decode_addr(addr_t addr, int nbanks);
        reg_sel_t sel;
        sel.bank = addr[REGION_BIT-1:SLOT_LSB];
        sel.kind = REG_NONE;
        if ((addr[SLOT_LSB-1:0] == '0) &&
            (addr[ADDR_W-1:REGION_BIT+1] == '0) &&
            (int'(sel.bank) < nbanks)) begin
            sel.kind = addr[REGION_BIT] ? REG_ENABLE : REG_CAUSE;
        end
        return sel;
    endfunction

    // Split an incoming vector number into bank and bit, dropping unbuilt banks.
    function automatic vec_evt_t split_vector(logic stb, vec_t num, int nbanks);
        vec_evt_t evt;
        evt.bank    = num[VEC_W-1:BIT_IDX_W];
        evt.bit_pos = num[BIT_IDX_W-1:0];
        evt.valid   = stb && (int'(evt.bank) < nbanks);
        return evt;
    endfunction

endpackage

// File: rtl/vecagg_decode.sv
module vecagg_decode
    import vecagg_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input  reg_req_t               req,
    output logic [NUM_BANKS-1:0]   cause_clr_sel,
    output logic [NUM_BANKS-1:0]   enable_wr_sel,
    output logic                   rd_fire,
    output reg_sel_t               rd_sel
);

    reg_sel_t sel;

    always_comb begin
        sel     = decode_addr(req.addr, NUM_BANKS);
        rd_fire = req.valid && !req.write;
        rd_sel  = sel;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
        logic hit;
        assign hit              = req.valid && req.write && (sel.bank == bank_idx_t'(b));
        assign cause_clr_sel[b] = hit && (sel.kind == REG_CAUSE);
        assign enable_wr_sel[b] = hit && (sel.kind == REG_ENABLE);
    end

endmodule

// File: rtl/vecagg_event.sv
module vecagg_event
    import vecagg_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input  logic                          vec_stb,
    input  vec_t                          vec_num,
    output logic [NUM_BANKS-1:0][WORD_W-1:0] set_mask
);

    vec_evt_t evt;
    word_t    bit_onehot;

    always_comb begin
        evt        = split_vector(vec_stb, vec_num, NUM_BANKS);
        bit_onehot = word_t'(1) << evt.bit_pos;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mask
        assign set_mask[b] = (evt.valid && (evt.bank == bank_idx_t'(b))) ? bit_onehot : '0;
    end

endmodule

// File: rtl/vecagg_bank.sv
module vecagg_bank
    import vecagg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t set_mask,
    input  logic  clr_sel,
    input  logic  en_sel,
    input  word_t wdata,
    output word_t cause_q,
    output word_t enable_q,
    output logic  irq
);

    word_t clr_mask;

    always_comb begin
        clr_mask = clr_sel ? wdata : '0;
    end

    // Set has priority over a clear of the same bit.
    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
        end else begin
            cause_q <= (cause_q & ~clr_mask) | set_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
        end else if (en_sel) begin
            enable_q <= wdata;
        end
    end

    assign irq = |(cause_q & enable_q);

endmodule

// File: rtl/vecagg_ctrl.sv
module vecagg_ctrl
    import vecagg_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vec_stb,
    input  logic [7:0]           vec_num,
    input  logic                 reg_valid,
    input  logic                 reg_write,
    input  logic [7:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic [NUM_BANKS-1:0] irq_out
);

    localparam int FLAT_W = NUM_BANKS * WORD_W;

    reg_req_t                         req;
    logic [NUM_BANKS-1:0]             cause_clr_sel;
    logic [NUM_BANKS-1:0]             enable_wr_sel;
    logic                             rd_fire;
    reg_sel_t                         rd_sel;
    logic [NUM_BANKS-1:0][WORD_W-1:0] set_mask;
    word_t                            cause_pad  [MAX_BANKS];
    word_t                            enable_pad [MAX_BANKS];
    logic [FLAT_W-1:0]                cause_flat;
    logic [FLAT_W-1:0]                en_flat;
    word_t                            rdata_q;

    always_comb begin
        req.valid = reg_valid;
        req.write = reg_write;
        req.addr  = reg_addr;
        req.wdata = reg_wdata;
    end

    vecagg_decode #(.NUM_BANKS(NUM_BANKS)) u_decode (
        .req           (req),
        .cause_clr_sel (cause_clr_sel),
        .enable_wr_sel (enable_wr_sel),
        .rd_fire       (rd_fire),
        .rd_sel        (rd_sel)
    );

    vecagg_event #(.NUM_BANKS(NUM_BANKS)) u_event (
        .vec_stb  (vec_stb),
        .vec_num  (vec_num),
        .set_mask (set_mask)
    );

    for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
        if (b < NUM_BANKS) begin : g_live
            word_t cause_w;
            word_t enable_w;
            vecagg_bank u_bank (
                .clk      (clk),
                .rst      (rst),
                .set_mask (set_mask[b]),
                .clr_sel  (cause_clr_sel[b]),
                .en_sel   (enable_wr_sel[b]),
                .wdata    (reg_wdata),
                .cause_q  (cause_w),
                .enable_q (enable_w),
                .irq      (irq_out[b])
            );
            assign cause_pad[b]                        = cause_w;
            assign enable_pad[b]                       = enable_w;
            assign cause_flat[b*WORD_W +: WORD_W]      = cause_w;
            assign en_flat[b*WORD_W +: WORD_W]         = enable_w;
        end else begin : g_absent
            assign cause_pad[b]  = '0;
            assign enable_pad[b] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_fire) begin
            unique case (rd_sel.kind)
                REG_CAUSE:  rdata_q <= cause_pad[rd_sel.bank];
                REG_ENABLE: rdata_q <= enable_pad[rd_sel.bank];
                default:    rdata_q <= '0;
            endcase
        end
    end

    assign reg_rdata = rdata_q;

endmodule

// File: rtl/vecagg_ctrl_chk.sv
module vecagg_ctrl_chk
    import vecagg_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        vec_stb,
    input logic [7:0]                  vec_num,
    input logic                        reg_valid,
    input logic                        reg_write,
    input logic [31:0]                 reg_rdata,
    input logic [NUM_BANKS-1:0]        irq_out,
    input logic [NUM_BANKS*WORD_W-1:0] cause_flat,
    input logic [NUM_BANKS*WORD_W-1:0] en_flat
);

    logic [MAX_BANKS*WORD_W-1:0] cause_wide;
    logic                        in_range;
    logic                        any_write;

    assign cause_wide = (MAX_BANKS*WORD_W)'(cause_flat);
    assign in_range   = int'(vec_num[VEC_W-1:BIT_IDX_W]) < NUM_BANKS;
    assign any_write  = reg_valid && reg_write;

    a_r2_event_sets_bit: assert property (@(posedge clk) disable iff (rst)
        (vec_stb && in_range && !any_write) |=> cause_wide[$past(vec_num)]);

    a_r4_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (vec_stb && in_range && any_write) |=> cause_wide[$past(vec_num)]);

    a_r3_cause_sticky: assert property (@(posedge clk) disable iff (rst)
        !any_write |=> ((cause_flat & $past(cause_flat)) == $past(cause_flat)));

    a_r6_enable_holds: assert property (@(posedge clk) disable iff (rst)
        !any_write |=> $stable(en_flat));

    a_r8_drop_out_of_range: assert property (@(posedge clk) disable iff (rst)
        (vec_stb && !in_range && !any_write) |=> $stable(cause_flat));

    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (en_flat == '0) |-> (irq_out == '0));

    a_r10_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        !(reg_valid && !reg_write) |=> $stable(reg_rdata));

endmodule

bind vecagg_ctrl vecagg_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .vec_stb    (vec_stb),
    .vec_num    (vec_num),
    .reg_valid  (reg_valid),
    .reg_write  (reg_write),
    .reg_rdata  (reg_rdata),
    .irq_out    (irq_out),
    .cause_flat (cause_flat),
    .en_flat    (en_flat)
);

// File: tb/test_vecagg_ctrl.sv
module test_vecagg_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          vec_stb = 1'b0;
    logic [7:0]    vec_num = '0;
    logic          reg_valid = 1'b0;
    logic          reg_write = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NB-1:0] irq_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vecagg_ctrl #(.NUM_BANKS(NB)) i_vecagg_ctrl (
        .clk       (clk),
        .rst       (rst),
        .vec_stb   (vec_stb),
        .vec_num   (vec_num),
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One cycle of stimulus, applied at a falling edge, then back to idle.
    task automatic drive(logic stb, logic [7:0] num, logic v, logic w,
                         logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        vec_stb   = stb;
        vec_num   = num;
        reg_valid = v;
        reg_write = w;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        vec_stb   = 1'b0;
        reg_valid = 1'b0;
        reg_write = 1'b0;
    endtask

    task automatic fire(logic [7:0] n);
        drive(1'b1, n, 1'b0, 1'b0, 8'h00, 32'h0);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        drive(1'b0, 8'h00, 1'b1, 1'b1, a, d);
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        drive(1'b0, 8'h00, 1'b1, 1'b0, a, 32'h0);
        d = reg_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1", "irq after reset", 32'(irq_out), 32'h0);
        check("R1", "rdata after reset", reg_rdata, 32'h0);
        for (int b = 0; b < NB; b++) begin
            rd(8'(4*b), v);
            check("R1", "cause after reset", v, 32'h0);
            rd(8'(8'h20 + 4*b), v);
            check("R1", "enable after reset", v, 32'h0);
        end
    endtask

    task automatic t_masked_latch;
        logic [31:0] v;
        fire(8'd37);
        check("R5", "irq with vector masked", 32'(irq_out), 32'h0);
        rd(8'h04, v);
        check("R2", "bank1 cause after vector 37", v, 32'h0000_0020);
    endtask

    task automatic t_enable_irq;
        logic [31:0] v;
        wr(8'h24, 32'h0000_0020);
        check("R7", "irq bank1 raised on unmask", 32'(irq_out), 32'h2);
        rd(8'h24, v);
        check("R6", "enable bank1 readback", v, 32'h0000_0020);
        rd(8'h20, v);
        check("R11", "enable bank0 untouched", v, 32'h0);
    endtask

    task automatic t_w1c;
        logic [31:0] v;
        wr(8'h04, 32'h0000_0000);
        rd(8'h04, v);
        check("R3", "zero write keeps cause", v, 32'h0000_0020);
        check("R7", "irq held while pending", 32'(irq_out), 32'h2);
        wr(8'h04, 32'h0000_0020);
        check("R7", "irq drops after clear", 32'(irq_out), 32'h0);
        rd(8'h04, v);
        check("R3", "cause cleared by one", v, 32'h0);
    endtask

    task automatic t_multi_bank;
        logic [31:0] v;
        fire(8'd0);
        fire(8'd31);
        fire(8'd191);
        rd(8'h00, v);
        check("R2", "bank0 bits 0 and 31", v, 32'h8000_0001);
        rd(8'h14, v);
        check("R2", "last bank bit 31", v, 32'h8000_0000);
        rd(8'h08, v);
        check("R11", "bank2 untouched", v, 32'h0);
        wr(8'h00, 32'h0000_0001);
        rd(8'h00, v);
        check("R3", "partial clear bank0", v, 32'h8000_0000);
        rd(8'h14, v);
        check("R11", "last bank kept on bank0 clear", v, 32'h8000_0000);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h00, v);
        check("R3", "bank0 fully cleared", v, 32'h0);
    endtask

    task automatic t_set_wins;
        logic [31:0] v;
        fire(8'd31);
        drive(1'b1, 8'd3, 1'b1, 1'b1, 8'h00, 32'h8000_0008);
        rd(8'h00, v);
        check("R4", "set beats clear, other bit cleared", v, 32'h0000_0008);
        wr(8'h00, 32'hFFFF_FFFF);
    endtask

    task automatic t_drop;
        logic [31:0] v;
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        fire(8'd200);
        fire(8'd255);
        check("R8", "no irq from dropped vectors", 32'(irq_out), 32'h0);
        for (int b = 0; b < NB; b++) begin
            rd(8'(4*b), v);
            check("R8", "cause after dropped vectors", v, 32'h0);
        end
        rd(8'h18, v);
        check("R9", "unbuilt bank cause reads zero", v, 32'h0);
        wr(8'h20, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        wr(8'h38, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h25, 32'hFFFF_FFFF);
        wr(8'hA4, 32'hFFFF_FFFF);
        rd(8'h24, v);
        check("R9", "enable bank1 unchanged by unmapped writes", v, 32'h0000_0020);
        rd(8'h25, v);
        check("R9", "misaligned read zero", v, 32'h0);
        rd(8'h24, v);
        rd(8'h64, v);
        check("R9", "out-of-range read zero", v, 32'h0);
        rd(8'h38, v);
        check("R9", "unbuilt enable reads zero", v, 32'h0);
        check("R9", "irq unchanged", 32'(irq_out), 32'h0);
    endtask

    task automatic t_read_timing;
        logic [31:0] v;
        rd(8'h24, v);
        wr(8'h28, 32'h0000_0000);
        fire(8'd5);
        repeat (3) @(negedge clk);
        check("R10", "rdata holds without read", reg_rdata, 32'h0000_0020);
        drive(1'b1, 8'd70, 1'b1, 1'b0, 8'h08, 32'h0);
        check("R10", "read shows value before edge", reg_rdata, 32'h0);
        rd(8'h08, v);
        check("R2", "bank2 bit6 after vector 70", v, 32'h0000_0040);
        wr(8'h28, 32'h0000_0040);
        check("R7", "irq bank2 raised", 32'(irq_out), 32'h4);
        wr(8'h28, 32'h0000_0000);
        check("R7", "irq bank2 masked again", 32'(irq_out), 32'h0);
        rd(8'h08, v);
        check("R3", "cause survives masking", v, 32'h0000_0040);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_masked_latch();
        t_enable_irq();
        t_w1c();
        t_multi_bank();
        t_set_wins();
        t_drop();
        t_unmapped();
        t_read_timing();
        finish_run();
    end

endmodule